// File: doc/BRIEF.md
# Four-Phase Completion Handshake Controller

This controller sits between a logic block's completion detectors and the environment that feeds the block. The environment raises a request. One or more detectors report, through active-high busy flags, that their part of the logic is still settling. The controller returns an acknowledge only when the result can be trusted. Acknowledge may rise only after two things: the request has been high for a programmable number of clock cycles, and no detector reports busy. The minimum wait covers switching activity too brief for a detector to notice. Once acknowledge is up, it follows the request back down after the synchronizer latency alone.

The request and all busy flags cross into the clock domain through two-flop synchronizers. Overall validity is the NOR of the synchronized busy flags. If the request is withdrawn before acknowledge rises, the handshake order is broken. The controller then emits a one-cycle error pulse, and its minimum-wait counter starts again from zero on the next request.

Top module: `hs_ctrl`

## Requirements
- R1: After reset, `ack` and `proto_err` are 0.
- R2: When `req_in` is first sampled high at clock edge 0 and no busy flag is sampled high, `ack` goes to 1 at edge DELAY_CYC+2 and not earlier.
- R3: A busy flag sampled high at edges s through s+w-1, with s no later than DELAY_CYC, holds `ack` low until edge max(DELAY_CYC+2, s+w+2).
- R4: Validity is the NOR of all NDET busy flags: any single flag, whatever its bit index, blocks the rise of `ack`.
- R5: Once `ack` is 1 and `req_in` is first sampled low at edge 0, `ack` stays 1 after edges 0 and 1 and is 0 from edge 2.
- R6: While `ack` and the request are both high, busy flags that rise again do not lower `ack`.
- R7: If `req_in` is first sampled low at edge 0 while `ack` is still 0, `proto_err` is 1 for exactly the cycle after edge 2, and `ack` stays 0.
- R8: After an aborted request, the next request again waits the full DELAY_CYC+2 edges.
- R9: While the request is low, busy activity leaves `ack` and `proto_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 1 | Request from the environment, asynchronous |
| det_busy | input | NDET | Per-detector busy flags, 1 while settling, asynchronous |
| ack | output | 1 | Acknowledge to the environment |
| proto_err | output | 1 | One-cycle pulse when the request is withdrawn before acknowledge |

## Verification
The hardest case to reach is a busy window that overlaps the end of the minimum wait. In that case a detector release decides the acknowledge edge by a single cycle, and so does counter expiry. Random transactions place the busy start anywhere from edge 0 to DELAY_CYC, with widths both shorter and longer than the remaining wait, so that both terms of the max formula win. Aborts are produced by dropping the request mid-wait while a detector is held busy, and each abort is followed by a clean request that shows the counter restarted.

// File: rtl/hs_ctrl.sv
module hs_ctrl #(
  parameter int NDET      = 3,
  parameter int DELAY_CYC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_in,
  input  logic [NDET-1:0] det_busy,
  output logic            ack,
  output logic            proto_err
);
  localparam int CW = $clog2(DELAY_CYC + 1);

  logic            req_m, req_s, req_q;
  logic [NDET-1:0] busy_m, busy_s;
  logic [CW-1:0]   cnt;
  logic            valid, dly_done;

  assign valid    = ~|busy_s;
  assign dly_done = (cnt == CW'(DELAY_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m  <= 1'b0;
      req_s  <= 1'b0;
      req_q  <= 1'b0;
      busy_m <= '0;
      busy_s <= '0;
    end else begin
      req_m  <= req_in;
      req_s  <= req_m;
      req_q  <= req_s;
      busy_m <= det_busy;
      busy_s <= busy_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!req_s)   cnt <= '0;
    else if (!dly_done) cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      ack       <= ack ? req_s : (req_s & dly_done & valid);
      proto_err <= req_q & ~req_s & ~ack;
    end
  end

  assert_rise_after_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(dly_done) && $past(req_s));
  assert_rise_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(valid));
  assert_fall_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> !$past(req_s));
  assert_ack_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && req_s |=> ack);
  assert_abort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_s) && !ack |=> proto_err);
  assert_err_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !ack);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_s && !ack |=> !ack);
endmodule

// File: tb/hs_ctrl_test.sv
module hs_ctrl_test;
  localparam int N = 3;
  localparam int D = 5;

  logic clk = 1'b0, rst_n = 1'b0, req_in = 1'b0;
  logic [N-1:0] det_busy = '0;
  logic ack, proto_err;
  int total = 0, bad = 0;
  bit finished = 0;

  hs_ctrl #(.NDET(N), .DELAY_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .det_busy(det_busy),
    .ack(ack), .proto_err(proto_err));

  always #2 clk = ~clk;

  function automatic int exp_rise(int s, int w);
    int a = D + 2;
    if (w > 0 && s + w + 2 > a) a = s + w + 2;
    return a;
  endfunction

  task automatic chk(string r, logic act, logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", r, act, expv, $time);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // full transaction: busy sampled at edges s..s+w-1 with mask m
  task automatic txn(int s, int w, logic [N-1:0] m, bit rebusy, string r);
    int e = exp_rise(s, w);
    @(negedge clk);
    req_in = 1'b1;
    det_busy = (w > 0 && s == 0) ? m : '0;
    for (int k = 0; k <= e + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(r, ack, (k >= e) ? 1'b1 : 1'b0);
      det_busy = (w > 0 && k + 1 >= s && k + 1 < s + w) ? m : '0;
    end
    if (rebusy) begin
      det_busy = m;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R6", ack, 1'b1);
      end
      det_busy = '0;
    end
    req_in = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R5", ack, (k < 2) ? 1'b1 : 1'b0);
      chk("R5", proto_err, 1'b0);
    end
  endtask

  // request dropped so that edge r is its last high sample
  task automatic abort(int r, bit hold_busy);
    @(negedge clk);
    req_in = 1'b1;
    det_busy = hold_busy ? 3'b010 : '0;
    for (int k = 0; k <= r + 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == r) req_in = 1'b0;
      chk("R7", ack, 1'b0);
      chk("R7", proto_err, (k == r + 3) ? 1'b1 : 1'b0);
    end
    det_busy = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(2);
    chk("R1", ack, 1'b0);
    chk("R1", proto_err, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    chk("R1", ack, 1'b0);

    txn(0, 0, '0, 0, "R2");
    txn(0, 2, 3'b001, 0, "R3");
    txn(D, 4, 3'b100, 0, "R3");
    txn(1, 9, 3'b001, 0, "R4");
    txn(2, 9, 3'b010, 0, "R4");
    txn(3, 9, 3'b100, 0, "R4");
    txn(0, 3, 3'b111, 1, "R6");

    abort(2, 1'b1);
    idle(3);
    txn(0, 0, '0, 0, "R8");
    abort(1, 1'b0);
    idle(3);
    txn(0, 0, '0, 0, "R8");

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      det_busy = N'($urandom);
      chk("R9", ack, 1'b0);
      chk("R9", proto_err, 1'b0);
    end
    det_busy = '0;
    idle(3);

    for (int i = 0; i < 40; i++) begin
      int s = int'($urandom % (D + 1));
      int w = int'($urandom % 9);
      logic [N-1:0] m = N'($urandom % ((1 << N) - 1) + 1);
      txn(s, w, m, bit'($urandom % 2), "R3");
      idle(int'($urandom % 3));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule